// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block takes one digitized pixel sample per pixel clock, with a horizontal sync level that is aligned to the samples. It routes the samples to one or two output data ports and makes a data clock that a downstream device can use to latch them. In dual-channel mode the samples are split in pairs. The sample that arrives on the sync leading edge always starts a pair on port A, and the sample after it completes the pair on port B. Both halves of a pair appear on the same clock edge. In single-channel mode every sample goes to port A, and port B is released through its output enable.

A flush counter tracks how many data sets have been presented since reset or since the last mode change, and raises a valid flag once the pipeline has been flushed. The number of invalid sets differs by mode. Analog sampling, clock synthesis and phase adjustment are handled elsewhere.

Top module: `pix_demux`

## Requirements
- R1: While reset is asserted, `a_data` and `b_data` are zero and `out_valid` and `b_oe` are low. After reset the registered mode is single-channel.
- R2: In single-channel mode, the sample presented at a clock edge appears on `a_data` after that edge. `b_oe` is low and `b_data` is zero.
- R3: In dual-channel mode, a sample presented in a cycle where `sync_in` is high and was low in the previous cycle (a leading edge) is captured as the A half of a pair. The next sample is the B half. At the edge that captures the B half, `a_data` takes the A half and `b_data` takes the B half together.
- R4: In dual-channel mode without a leading edge, samples keep alternating A, B, A, B from the last pair start.
- R5: A leading edge that arrives while a B half is expected drops the pending A half. The leading-edge sample becomes the new A half.
- R6: `b_oe` is high exactly when the registered mode is dual-channel.
- R7: In dual-channel mode, `dclk_out` is high after an edge that captures an A half and low after an edge that outputs a pair. In single-channel mode, `dclk_out` is the inverted pixel clock, so its rising edge falls midway between `a_data` updates.
- R8: In single-channel mode, the first four `a_data` updates after a flush restart are invalid, and `out_valid` rises with the fifth update.
- R9: In dual-channel mode, the first two pair outputs after a flush restart are invalid, and `out_valid` rises with the third.
- R10: When `dual_mode` differs from the registered mode at an edge, several things happen at that edge: the mode register takes the new value, the sample is discarded, `out_valid` clears, the flush count restarts and the pair selector returns to A. Port B is zeroed when the new mode is single-channel.
- R11: In dual-channel mode, an edge that only captures an A half leaves `a_data` and `b_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_mode | input | 1 | 1 selects dual-channel, 0 selects single-channel |
| samp_in | input | SAMP_W | Pixel sample for this clock |
| sync_in | input | 1 | Horizontal sync level, aligned to samp_in |
| a_data | output | SAMP_W | Port A data |
| b_data | output | SAMP_W | Port B data |
| b_oe | output | 1 | Port B output enable |
| dclk_out | output | 1 | Output data clock |
| out_valid | output | 1 | Pipeline flushed, output data valid |

## Verification
The assertions assume that `sync_in` and `dual_mode` are synchronous to `clk` and settle before each rising edge. They also assume that a leading edge is defined against the previous cycle's sync level, including the cycle in which the mode changes. The bench drives every input at the falling edge only. It builds lines of random length with a sync pulse of one to three cycles, and it changes mode only between whole runs of lines. Directed sequences add the cases the random lines reach rarely: a sync edge that lands on an expected B half, and a mode switch after valid has been reached.

// File: rtl/pdmx_pkg.sv
package pdmx_pkg;
  // Number of invalid data sets presented before valid, by mode.
  function automatic int unsigned flush_len(input logic dual,
                                            input int unsigned single_n,
                                            input int unsigned dual_n);
    return dual ? dual_n : single_n;
  endfunction

  // Next selector value: 1 means the next sample is a B half.
  function automatic logic next_sel(input logic dual, input logic to_a);
    return dual & to_a;
  endfunction
endpackage

// File: rtl/pdmx_steer.sv
module pdmx_steer (
  input  logic clk,
  input  logic rst_n,
  input  logic dual_i,
  input  logic hold_i,
  input  logic sync_i,
  output logic lead_o,
  output logic to_a_o,
  output logic sel_b_o
);
  import pdmx_pkg::*;

  logic sync_d;
  logic sel_b;

  assign lead_o  = sync_i & ~sync_d;
  assign to_a_o  = ~dual_i | lead_o | ~sel_b;
  assign sel_b_o = sel_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_d <= 1'b0;
      sel_b  <= 1'b0;
    end else begin
      sync_d <= sync_i;
      if (hold_i) sel_b <= 1'b0;
      else        sel_b <= next_sel(dual_i, to_a_o);
    end
  end

  // A leading edge in dual mode must leave the selector pointing at B
  assert_lead_starts_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_i && !hold_i && lead_o) |=> sel_b);

  // A mode change returns the selector to A
  assert_hold_clears_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !sel_b);
endmodule

// File: rtl/pdmx_flush.sv
module pdmx_flush #(
  parameter int unsigned SINGLE_FLUSH = 4,
  parameter int unsigned DUAL_FLUSH   = 2,
  localparam int unsigned MAXF  = (SINGLE_FLUSH > DUAL_FLUSH) ? SINGLE_FLUSH : DUAL_FLUSH,
  localparam int unsigned CNT_W = $clog2(MAXF + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dual_i,
  input  logic restart_i,
  input  logic step_i,
  output logic valid_o
);
  import pdmx_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             valid_q;

  assign limit   = CNT_W'(flush_len(dual_i, SINGLE_FLUSH, DUAL_FLUSH));
  assign valid_o = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      valid_q <= 1'b0;
    end else if (restart_i) begin
      cnt     <= '0;
      valid_q <= 1'b0;
    end else if (step_i) begin
      valid_q <= (cnt >= limit);
      if (cnt < limit) cnt <= cnt + 1'b1;
    end
  end

  // Valid may only rise on an edge that presents a data set
  assert_valid_on_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(step_i));

  // Restart always clears valid
  assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !valid_o);
endmodule

// File: rtl/pix_demux.sv
module pix_demux #(
  parameter int unsigned SAMP_W       = 10,
  parameter int unsigned SINGLE_FLUSH = 4,
  parameter int unsigned DUAL_FLUSH   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dual_mode,
  input  logic [SAMP_W-1:0] samp_in,
  input  logic              sync_in,
  output logic [SAMP_W-1:0] a_data,
  output logic [SAMP_W-1:0] b_data,
  output logic              b_oe,
  output logic              dclk_out,
  output logic              out_valid
);
  logic              mode_q;
  logic              mode_chg;
  logic              lead;
  logic              to_a;
  logic              sel_b;
  logic              pair_fire;
  logic              a_capture;
  logic              single_fire;
  logic              step;
  logic              dclk_q;
  logic [SAMP_W-1:0] a_hold;

  assign mode_chg    = dual_mode ^ mode_q;
  assign single_fire = ~mode_chg & ~mode_q;
  assign a_capture   = ~mode_chg &  mode_q &  to_a;
  assign pair_fire   = ~mode_chg &  mode_q & ~to_a;
  assign step        = single_fire | pair_fire;

  pdmx_steer u_steer (
    .clk    (clk),
    .rst_n  (rst_n),
    .dual_i (mode_q),
    .hold_i (mode_chg),
    .sync_i (sync_in),
    .lead_o (lead),
    .to_a_o (to_a),
    .sel_b_o(sel_b)
  );

  pdmx_flush #(
    .SINGLE_FLUSH(SINGLE_FLUSH),
    .DUAL_FLUSH  (DUAL_FLUSH)
  ) u_flush (
    .clk      (clk),
    .rst_n    (rst_n),
    .dual_i   (mode_q),
    .restart_i(mode_chg),
    .step_i   (step),
    .valid_o  (out_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      a_hold <= '0;
      a_data <= '0;
      b_data <= '0;
      dclk_q <= 1'b0;
    end else begin
      if (mode_chg) begin
        mode_q <= dual_mode;
        dclk_q <= 1'b0;
        if (!dual_mode) b_data <= '0;
      end
      if (single_fire) a_data <= samp_in;
      if (a_capture) begin
        a_hold <= samp_in;
        dclk_q <= 1'b1;
      end
      if (pair_fire) begin
        a_data <= a_hold;
        b_data <= samp_in;
        dclk_q <= 1'b0;
      end
    end
  end

  assign b_oe     = mode_q;
  assign dclk_out = mode_q ? dclk_q : ~clk;

  // Port B carries no data while it is released
  assert_b_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !b_oe |-> (b_data == '0));

  // An A-only capture leaves both ports stable
  assert_a_capture_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    a_capture |=> ($stable(a_data) && $stable(b_data)));

  // Dual-mode valid rises only with a pair output
  assert_dual_valid_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && mode_q) |-> $past(pair_fire));

  // Data clock falls with a pair and is high after an A capture
  assert_dclk_pair_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_fire |=> !dclk_out);
  assert_dclk_capture_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    a_capture |=> dclk_q);

  // The leading-edge sample is always captured as an A half
  assert_lead_to_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lead && mode_q && !mode_chg) |-> to_a);

  // Port B enable follows the mode after a change
  assert_oe_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (b_oe == $past(dual_mode)));

  // Single mode keeps the selector on A
  assert_single_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !mode_chg) |=> !sel_b);
endmodule

// File: tb/sim_pix_demux.sv
module sim_pix_demux;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dual_mode = 1'b0;
  logic [W-1:0] samp_in = '0;
  logic         sync_in = 1'b0;
  logic [W-1:0] a_data, b_data;
  logic         b_oe, dclk_out, out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string dual_tag = "R3";

  // expectation state
  logic         e_mode, e_wait_b, e_prev_sync, e_valid, e_dclk;
  logic [W-1:0] e_pend, e_a, e_b;
  int           e_sets;

  always #10 clk = ~clk;

  pix_demux #(.SAMP_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .samp_in(samp_in),
    .sync_in(sync_in), .a_data(a_data), .b_data(b_data), .b_oe(b_oe),
    .dclk_out(dclk_out), .out_valid(out_valid)
  );

  function automatic int invalid_sets(input logic dual);
    if (dual) return 2;
    return 4;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    e_mode = 0; e_wait_b = 0; e_prev_sync = 0; e_valid = 0; e_dclk = 0;
    e_pend = '0; e_a = '0; e_b = '0; e_sets = 0;
  endtask

  // expected state after the coming rising edge
  task automatic model_step(input logic md, input logic sy, input logic [W-1:0] s);
    logic edge_seen;
    if (md != e_mode) begin
      e_mode = md; e_wait_b = 0; e_sets = 0; e_valid = 0; e_dclk = 0;
      if (!md) e_b = '0;
      e_prev_sync = sy;
      return;
    end
    edge_seen = sy && !e_prev_sync;
    e_prev_sync = sy;
    if (!e_mode) begin
      e_sets++;
      e_a = s;
      e_valid = (e_sets > invalid_sets(0));
    end else if (edge_seen || !e_wait_b) begin
      e_pend = s; e_wait_b = 1; e_dclk = 1;
    end else begin
      e_sets++;
      e_a = e_pend; e_b = s; e_wait_b = 0; e_dclk = 0;
      e_valid = (e_sets > invalid_sets(1));
    end
  endtask

  task automatic compare();
    chk(a_data == e_a, e_mode ? dual_tag : "R2", a_data, e_a);
    chk(b_data == e_b, e_mode ? dual_tag : "R2", b_data, e_b);
    chk(b_oe == e_mode, "R6", b_oe, e_mode);
    chk(out_valid == e_valid, e_mode ? "R9" : "R8", out_valid, e_valid);
    if (e_mode) chk(dclk_out == e_dclk, "R7", dclk_out, e_dclk);
    else        chk(dclk_out == 1'b1, "R7", dclk_out, 1); // clk low at sample point
  endtask

  // called at a falling edge: drive, predict, wait, compare
  task automatic cyc(input logic md, input logic sy, input logic [W-1:0] s);
    dual_mode = md; sync_in = sy; samp_in = s;
    model_step(md, sy, s);
    @(negedge clk);
    compare();
  endtask

  task automatic rand_lines(input logic md, input int n);
    for (int l = 0; l < n; l++) begin
      int len = 6 + int'($urandom_range(14));
      int sw  = 1 + int'($urandom_range(2));
      for (int p = 0; p < len; p++) cyc(md, p < sw, W'($urandom));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(a_data == '0, "R1", a_data, 0);
    chk(b_data == '0, "R1", b_data, 0);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(b_oe == 1'b0, "R1", b_oe, 0);
    rst_n = 1'b1;

    // R2, R8: single-channel run, valid after four updates
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, W'(i + 1));
      chk(out_valid == 1'b0, "R8", out_valid, 0);
    end
    cyc(0, 0, W'(5));
    chk(out_valid == 1'b1, "R8", out_valid, 1);
    rand_lines(0, 5);

    // R10: switch to dual, sample dropped and valid cleared
    cyc(1, 0, W'(9));
    chk(out_valid == 1'b0, "R10", out_valid, 0);
    chk(a_data == e_a, "R10", a_data, e_a);

    // R3, R9: first pairs from a leading edge
    dual_tag = "R3";
    cyc(1, 1, 10'h011);
    cyc(1, 1, 10'h022);
    chk(a_data == 10'h011 && b_data == 10'h022, "R3", a_data, 10'h011);
    chk(out_valid == 1'b0, "R9", out_valid, 0);
    cyc(1, 0, 10'h033);
    chk(a_data == 10'h011, "R11", a_data, 10'h011);
    cyc(1, 0, 10'h044);
    chk(out_valid == 1'b0, "R9", out_valid, 0);
    cyc(1, 0, 10'h055);
    cyc(1, 0, 10'h066);
    chk(out_valid == 1'b1, "R9", out_valid, 1);

    // R5: leading edge while a B half is expected
    dual_tag = "R5";
    cyc(1, 0, 10'h077);
    cyc(1, 1, 10'h088);
    cyc(1, 0, 10'h099);
    chk(a_data == 10'h088 && b_data == 10'h099, "R5", a_data, 10'h088);

    // R4, R11: random dual lines
    dual_tag = "R4";
    rand_lines(1, 12);

    // R10: back to single, port B cleared and flush restarts
    cyc(0, 0, W'(3));
    chk(out_valid == 1'b0, "R10", out_valid, 0);
    chk(b_data == '0 && b_oe == 1'b0, "R10", b_data, 0);
    rand_lines(0, 4);
    for (int k = 0; k < 6; k++) begin
      dual_tag = "R4";
      rand_lines(1, 3);
      rand_lines(0, 2);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule